// File: doc/BRIEF.md
# Multilevel Integer 5/3 Lifting Wavelet Engine

This block applies a reversible two-dimensional integer wavelet transform of the 5/3 kind to an image held in its own word-addressed RAM. The host loads pixels through a simple write port, then starts a run with the image size, a level count and a direction bit. In forward (analysis) mode, each level first transforms every row and then every column. In inverse (synthesis) mode, the levels are undone from the deepest one outward, with columns undone before rows. After a run the host reads coefficients or restored pixels back through the same port.

The coefficients are kept in place and interleaved. After a level, low-pass values sit at the even positions of that level's sub-grid and high-pass values sit at the odd positions. Level `l` works on the grid of pixels whose row and column are both multiples of 2^l, so any width and height up to the maximum can be used. All scaling and rounding is done with arithmetic shifts and adds. Three modules carry the work: a line engine that loads, lifts and stores one line; a level-parameter unit that gives the grid size and address steps for each level; and an outer sequencer.

Top module: `lift53_engine`

## Requirements
- R1: After reset, `busy_o` and `done_o` are both 0.
- R2: In forward mode, each odd line position i becomes x[i] - ((x[i-1] + x[i+1]) >>> 1), where >>> is arithmetic shift (floor division). A line [10,20,30,40] becomes [10,0,33,10].
- R3: In forward mode, each even line position i becomes x[i] + ((d[i-1] + d[i+1] + 2) >>> 2), using the high-pass values already computed.
- R4: Line ends use symmetric extension: a missing neighbour at index i+1 is replaced by the one at i-1, and at index 0 the missing left neighbour is replaced by index 1. An odd length keeps one extra low-pass value at the end. A line [4,8,6,2,9] becomes [6,3,6,-5,7].
- R5: Pixel (row r, column c) lives at address r*MAX_W + c. Level l works only on addresses whose row and column are multiples of 2^l, over a ceil(H/2^l) by ceil(W/2^l) grid. No other address changes.
- R6: A forward run with L levels does levels 0 to L-1 in order, each as a full row pass followed by a full column pass.
- R7: An inverse run with the same size and level count, applied to the forward result, returns the original image bit for bit.
- R8: `busy_o` is high from the cycle after an accepted start until the run ends. `done_o` is then high for exactly one cycle, in which `busy_o` is low.
- R9: Host writes presented while `busy_o` is high do not change the memory.
- R10: A start with a level count of 0 produces `done_o` on the next cycle and leaves the memory unchanged. A level count above MAX_LEVELS is treated as MAX_LEVELS.
- R11: `start_i` is ignored while `busy_o` is high. The running transform keeps its direction, size and level count.
- R12: Lines of length 1 pass through unchanged, so a 1x1 image is never altered.
- R13: `mem_rdata_o` shows the word at `mem_addr_i` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (accepted when idle) |
| inverse_i | input | 1 | 0 selects analysis, 1 selects synthesis |
| width_i | input | DIM_W | Image width, 1 to MAX_W |
| height_i | input | DIM_W | Image height, 1 to MAX_H |
| levels_i | input | LVL_W | Number of decomposition levels |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mem_we_i | input | 1 | Host write enable |
| mem_addr_i | input | AW | Host word address |
| mem_wdata_i | input | DATA_W | Host write data (signed) |
| mem_rdata_o | output | DATA_W | Registered read data (signed) |

## Verification
Assertions check on every cycle that:
- the predict step only visits odd indices and the update step only visits even ones, always inside the current line length;
- memory is written only during a line's store phase;
- the level index stays below the level count;
- the configuration holds steady while busy;
- `done_o` is a single pulse that ends `busy_o`.

Only the bench scenarios can show the coefficient values, the rounding of negative sums, symmetric extension at odd lengths, exact reconstruction, and that host writes and starts made mid-run leave the result intact. These results are compared against a bench model over the whole memory.

// File: rtl/lift53_pkg.sv
package lift53_pkg;
  typedef enum logic [2:0] {
    LS_IDLE, LS_LOAD, LS_PRED, LS_UPD, LS_STORE, LS_FIN
  } line_st_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE
  } seq_st_e;

  typedef enum logic {
    PASS_ROW, PASS_COL
  } pass_e;
endpackage

// File: rtl/lift53_analysis.sv
// Forward lifting kernel: predict subtracts half-sum, update adds quarter-sum rounded.
module lift53_analysis #(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] ctr_i,
  input  logic signed [DATA_W-1:0] nb_a_i,
  input  logic signed [DATA_W-1:0] nb_b_i,
  input  logic                     upd_i,
  output logic signed [DATA_W-1:0] res_o
);
  logic signed [DATA_W+1:0] sum, rnd, term;

  always_comb begin
    rnd  = upd_i ? (DATA_W+2)'(2) : '0;
    sum  = $signed({{2{nb_a_i[DATA_W-1]}}, nb_a_i})
         + $signed({{2{nb_b_i[DATA_W-1]}}, nb_b_i}) + rnd;
    term = upd_i ? (sum >>> 2) : (sum >>> 1);
    res_o = upd_i ? ctr_i + term[DATA_W-1:0] : ctr_i - term[DATA_W-1:0];
  end
endmodule

// File: rtl/lift53_synthesis.sv
// Inverse lifting kernel: same terms as analysis with opposite sign.
module lift53_synthesis #(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] ctr_i,
  input  logic signed [DATA_W-1:0] nb_a_i,
  input  logic signed [DATA_W-1:0] nb_b_i,
  input  logic                     upd_i,
  output logic signed [DATA_W-1:0] res_o
);
  logic signed [DATA_W+1:0] sum, rnd, term;

  always_comb begin
    rnd  = upd_i ? (DATA_W+2)'(2) : '0;
    sum  = $signed({{2{nb_a_i[DATA_W-1]}}, nb_a_i})
         + $signed({{2{nb_b_i[DATA_W-1]}}, nb_b_i}) + rnd;
    term = upd_i ? (sum >>> 2) : (sum >>> 1);
    res_o = upd_i ? ctr_i - term[DATA_W-1:0] : ctr_i + term[DATA_W-1:0];
  end
endmodule

// File: rtl/lift53_level_params.sv
// Per-level grid size and address steps, shifts only.
module lift53_level_params #(
  parameter int MAX_W = 16,
  parameter int DIM_W = 5,
  parameter int LVL_W = 2,
  parameter int AW    = 8
) (
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [DIM_W-1:0] n_cols_o,
  output logic [DIM_W-1:0] n_rows_o,
  output logic [AW-1:0]    step_o,
  output logic [AW-1:0]    row_pitch_o
);
  always_comb begin
    n_cols_o    = ((width_i  - 1'b1) >> lvl_i) + 1'b1;
    n_rows_o    = ((height_i - 1'b1) >> lvl_i) + 1'b1;
    step_o      = AW'(1) << lvl_i;
    row_pitch_o = AW'(MAX_W) << lvl_i;
  end
endmodule

// File: rtl/lift53_line_unit.sv
// One line: load into buffer, lift in place, store back.
module lift53_line_unit
  import lift53_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LEN = 16,
  parameter int AW      = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              inverse_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     stride_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o
);
  localparam int BUF_D = 1 << LEN_W;

  line_st_e st_q;
  logic [LEN_W-1:0] idx_q, len_q, lidx, ridx;
  logic [LEN_W:0]   idx_nx2;
  logic             inv_q;
  logic [AW-1:0]    addr_q, base_q, stride_q;
  logic signed [DATA_W-1:0] buf_q [BUF_D];
  logic signed [DATA_W-1:0] ana_val, syn_val, new_val;
  logic             is_upd, last_idx;

  always_comb begin
    idx_nx2  = {1'b0, idx_q} + (LEN_W+1)'(2);
    last_idx = (idx_q == len_q - 1'b1);
    lidx     = (idx_q == '0) ? LEN_W'(1) : idx_q - 1'b1;
    ridx     = ({1'b0, idx_q} + 1'b1 < {1'b0, len_q}) ? idx_q + 1'b1 : idx_q - 1'b1;
    is_upd   = (st_q == LS_UPD);
  end

  lift53_analysis #(.DATA_W(DATA_W)) u_ana (
    .ctr_i(buf_q[idx_q]), .nb_a_i(buf_q[lidx]), .nb_b_i(buf_q[ridx]),
    .upd_i(is_upd), .res_o(ana_val)
  );

  lift53_synthesis #(.DATA_W(DATA_W)) u_syn (
    .ctr_i(buf_q[idx_q]), .nb_a_i(buf_q[lidx]), .nb_b_i(buf_q[ridx]),
    .upd_i(is_upd), .res_o(syn_val)
  );

  assign new_val = inv_q ? syn_val : ana_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= LS_IDLE;
      idx_q    <= '0;
      len_q    <= '0;
      inv_q    <= 1'b0;
      addr_q   <= '0;
      base_q   <= '0;
      stride_q <= '0;
    end else begin
      case (st_q)
        LS_IDLE: if (start_i) begin
          inv_q    <= inverse_i;
          len_q    <= len_i;
          base_q   <= base_i;
          stride_q <= stride_i;
          addr_q   <= base_i;
          idx_q    <= '0;
          st_q     <= LS_LOAD;
        end
        LS_LOAD: begin
          addr_q <= addr_q + stride_q;
          if (last_idx) begin
            addr_q <= base_q;
            if (len_q < LEN_W'(2)) begin
              st_q <= LS_STORE; idx_q <= '0;
            end else if (inv_q) begin
              st_q <= LS_UPD;   idx_q <= '0;
            end else begin
              st_q <= LS_PRED;  idx_q <= LEN_W'(1);
            end
          end else idx_q <= idx_q + 1'b1;
        end
        LS_PRED: begin
          if (idx_nx2 >= {1'b0, len_q}) begin
            idx_q <= '0;
            st_q  <= inv_q ? LS_STORE : LS_UPD;
          end else idx_q <= idx_nx2[LEN_W-1:0];
        end
        LS_UPD: begin
          if (idx_nx2 >= {1'b0, len_q}) begin
            if (inv_q) begin
              st_q <= LS_PRED; idx_q <= LEN_W'(1);
            end else begin
              st_q <= LS_STORE; idx_q <= '0;
            end
          end else idx_q <= idx_nx2[LEN_W-1:0];
        end
        LS_STORE: begin
          addr_q <= addr_q + stride_q;
          if (last_idx) st_q <= LS_FIN;
          else idx_q <= idx_q + 1'b1;
        end
        LS_FIN:  st_q <= LS_IDLE;
        default: st_q <= LS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (st_q == LS_LOAD) buf_q[idx_q] <= mem_rdata_i;
    else if (st_q == LS_PRED || st_q == LS_UPD) buf_q[idx_q] <= new_val;
  end

  assign mem_addr_o  = addr_q;
  assign mem_we_o    = (st_q == LS_STORE);
  assign mem_wdata_o = buf_q[idx_q];
  assign done_o      = (st_q == LS_FIN);

  a_r4_idx_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LS_PRED || st_q == LS_UPD) |-> idx_q < len_q);
  a_r2_pred_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LS_PRED) |-> idx_q[0]);
  a_r3_upd_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LS_UPD) |-> !idx_q[0]);
  a_r5_write_after_lift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(st_q) != LS_IDLE);
endmodule

// File: rtl/lift53_engine.sv
module lift53_engine
  import lift53_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MAX_W      = 16,
  parameter int MAX_H      = 16,
  parameter int MAX_LEVELS = 3,
  localparam int AW        = $clog2(MAX_W * MAX_H),
  localparam int MAX_LEN   = (MAX_W > MAX_H) ? MAX_W : MAX_H,
  localparam int DIM_W     = $clog2(MAX_LEN + 1),
  localparam int LVL_W     = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              inverse_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [LVL_W-1:0]  levels_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              mem_we_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [DATA_W-1:0] mem_wdata_i,
  output logic [DATA_W-1:0] mem_rdata_o
);
  localparam int MEM_D = 1 << AW;

  seq_st_e st_q;
  pass_e   pass_q;
  logic             inv_q;
  logic [DIM_W-1:0] cfg_w_q, cfg_h_q, line_q;
  logic [LVL_W-1:0] cfg_lv_q, lvl_q, lv_in;
  logic [AW-1:0]    line_base_q;

  logic [DIM_W-1:0] n_cols, n_rows, n_lines, ln_len;
  logic [AW-1:0]    step, row_pitch, line_pitch, ln_stride;
  logic             ln_done, eng_we;
  logic [AW-1:0]    eng_addr;
  logic [DATA_W-1:0] eng_wdata, eng_rdata;
  logic [DATA_W-1:0] mem_q [MEM_D];

  lift53_level_params #(.MAX_W(MAX_W), .DIM_W(DIM_W), .LVL_W(LVL_W), .AW(AW)) u_par (
    .width_i(cfg_w_q), .height_i(cfg_h_q), .lvl_i(lvl_q),
    .n_cols_o(n_cols), .n_rows_o(n_rows), .step_o(step), .row_pitch_o(row_pitch)
  );

  always_comb begin
    lv_in      = (levels_i > LVL_W'(MAX_LEVELS)) ? LVL_W'(MAX_LEVELS) : levels_i;
    n_lines    = (pass_q == PASS_ROW) ? n_rows    : n_cols;
    ln_len     = (pass_q == PASS_ROW) ? n_cols    : n_rows;
    line_pitch = (pass_q == PASS_ROW) ? row_pitch : step;
    ln_stride  = (pass_q == PASS_ROW) ? step      : row_pitch;
  end

  lift53_line_unit #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .AW(AW), .LEN_W(DIM_W)) u_line (
    .clk_i, .rst_ni,
    .start_i(st_q == SQ_ISSUE), .inverse_i(inv_q),
    .base_i(line_base_q), .stride_i(ln_stride), .len_i(ln_len),
    .mem_rdata_i(eng_rdata), .mem_addr_o(eng_addr), .mem_we_o(eng_we),
    .mem_wdata_o(eng_wdata), .done_o(ln_done)
  );

  // Outer sequencer: level loop around row/column passes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      pass_q      <= PASS_ROW;
      inv_q       <= 1'b0;
      cfg_w_q     <= DIM_W'(1);
      cfg_h_q     <= DIM_W'(1);
      cfg_lv_q    <= '0;
      lvl_q       <= '0;
      line_q      <= '0;
      line_base_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_i) begin
          inv_q       <= inverse_i;
          cfg_w_q     <= width_i;
          cfg_h_q     <= height_i;
          cfg_lv_q    <= lv_in;
          line_q      <= '0;
          line_base_q <= '0;
          lvl_q       <= inverse_i ? lv_in - 1'b1 : '0;
          pass_q      <= inverse_i ? PASS_COL : PASS_ROW;
          st_q        <= (lv_in == '0) ? SQ_DONE : SQ_ISSUE;
        end
        SQ_ISSUE: st_q <= SQ_WAIT;
        SQ_WAIT: if (ln_done) begin
          if ({1'b0, line_q} + 1'b1 < {1'b0, n_lines}) begin
            line_q      <= line_q + 1'b1;
            line_base_q <= line_base_q + line_pitch;
            st_q        <= SQ_ISSUE;
          end else begin
            line_q      <= '0;
            line_base_q <= '0;
            st_q        <= SQ_ISSUE;
            if (!inv_q) begin
              if (pass_q == PASS_ROW) pass_q <= PASS_COL;
              else if (lvl_q + 1'b1 < cfg_lv_q) begin
                lvl_q <= lvl_q + 1'b1; pass_q <= PASS_ROW;
              end else st_q <= SQ_DONE;
            end else begin
              if (pass_q == PASS_COL) pass_q <= PASS_ROW;
              else if (lvl_q != '0) begin
                lvl_q <= lvl_q - 1'b1; pass_q <= PASS_COL;
              end else st_q <= SQ_DONE;
            end
          end
        end
        SQ_DONE: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q == SQ_ISSUE) || (st_q == SQ_WAIT);
  assign done_o    = (st_q == SQ_DONE);
  assign eng_rdata = mem_q[eng_addr];

  always_ff @(posedge clk_i) begin
    if (busy_o) begin
      if (eng_we) mem_q[eng_addr] <= eng_wdata;
    end else if (mem_we_i) mem_q[mem_addr_i] <= mem_wdata_i;
    mem_rdata_o <= mem_q[mem_addr_i];
  end

  a_r6_level_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> lvl_q < cfg_lv_q);
  a_r11_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(inv_q) && $stable(cfg_lv_q) &&
                                   $stable(cfg_w_q) && $stable(cfg_h_q)));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_busy_ends_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/sim_lift53_engine.sv
module sim_lift53_engine;
  localparam int MW = 16, MH = 16, DEPTH = MW * MH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, inv = 0, we = 0;
  logic [4:0] wid = 5'd1, hgt = 5'd1;
  logic [1:0] lvls = 2'd0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0;
  logic busy, done;
  logic [15:0] rdata;

  int n_checks = 0, n_err = 0;
  int orig [DEPTH];
  int mdl  [DEPTH];

  always #2.5 clk = ~clk;

  lift53_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .inverse_i(inv),
    .width_i(wid), .height_i(hgt), .levels_i(lvls),
    .busy_o(busy), .done_o(done),
    .mem_we_i(we), .mem_addr_i(addr), .mem_wdata_i(wdata), .mem_rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int w16(input int v);
    return int'(shortint'(v));
  endfunction

  task automatic model_line(input bit iv, input int base, input int stride, input int n);
    int ln [16];
    for (int i = 0; i < n; i++) ln[i] = mdl[base + i*stride];
    if (n >= 2) begin
      if (!iv) begin
        for (int i = 1; i < n; i += 2) begin
          int rt = (i + 1 < n) ? ln[i+1] : ln[i-1];
          ln[i] = w16(ln[i] - ((ln[i-1] + rt) >>> 1));
        end
        for (int i = 0; i < n; i += 2) begin
          int lf = (i == 0) ? ln[1] : ln[i-1];
          int rt = (i + 1 < n) ? ln[i+1] : ln[i-1];
          ln[i] = w16(ln[i] + ((lf + rt + 2) >>> 2));
        end
      end else begin
        for (int i = 0; i < n; i += 2) begin
          int lf = (i == 0) ? ln[1] : ln[i-1];
          int rt = (i + 1 < n) ? ln[i+1] : ln[i-1];
          ln[i] = w16(ln[i] - ((lf + rt + 2) >>> 2));
        end
        for (int i = 1; i < n; i += 2) begin
          int rt = (i + 1 < n) ? ln[i+1] : ln[i-1];
          ln[i] = w16(ln[i] + ((ln[i-1] + rt) >>> 1));
        end
      end
    end
    for (int i = 0; i < n; i++) mdl[base + i*stride] = ln[i];
  endtask

  task automatic model_pass(input bit iv, input bit col, input int l, input int w, input int h);
    int st = 1 << l;
    int nr = ((h - 1) >> l) + 1;
    int nc = ((w - 1) >> l) + 1;
    if (!col) for (int r = 0; r < nr; r++) model_line(iv, r*st*MW, st, nc);
    else      for (int c = 0; c < nc; c++) model_line(iv, c*st, st*MW, nr);
  endtask

  task automatic model_run(input bit iv, input int w, input int h, input int l);
    if (!iv) for (int k = 0; k < l; k++) begin
      model_pass(0, 0, k, w, h); model_pass(0, 1, k, w, h);
    end else for (int k = l - 1; k >= 0; k--) begin
      model_pass(1, 1, k, w, h); model_pass(1, 0, k, w, h);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1; addr = 8'(a); wdata = 16'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 8'(a);
    @(negedge clk); v = int'($signed(rdata));
  endtask

  task automatic load_all();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); we = 1; addr = 8'(a); wdata = 16'(orig[a]);
      mdl[a] = orig[a];
    end
    @(negedge clk); we = 0;
  endtask

  task automatic compare_all(input string req);
    int v, bad = 0, fa = 0, fv = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      if (v != mdl[a] && bad == 0) begin fa = a; fv = v; end
      if (v != mdl[a]) bad++;
    end
    chk(bad == 0, $sformatf("%s pixel %0d", req, fa), fv, mdl[fa]);
  endtask

  task automatic run(input bit iv, input int w, input int h, input int l, input bit disturb);
    int cyc = 0;
    @(negedge clk);
    inv = iv; wid = 5'(w); hgt = 5'(h); lvls = 2'(l); start = 1;
    @(negedge clk); start = 0;
    if (l > 0) chk(busy == 1, "R8 busy after start", int'(busy), 1);
    while (!done && cyc < 20000) begin
      if (disturb && cyc == 3) begin
        we = 1; addr = 8'd0; wdata = 16'h1234; start = 1; inv = ~iv; lvls = 2'd1;
      end else begin
        we = 0; start = 0;
      end
      @(negedge clk); cyc++;
    end
    we = 0; start = 0;
    chk(done == 1, "R8 watchdog", cyc, -1);
    chk(busy == 0, "R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 0, "R8 done single pulse", int'(done), 0);
    model_run(iv, w, h, l);
  endtask

  initial begin
    int v;
    int exp4 [4] = '{10, 0, 33, 10};
    int exp5 [5] = '{6, 3, 6, -5, 7};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset outputs", int'({busy, done}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 idle after reset", int'({busy, done}), 0);

    // R13 readback latency
    wr(37, -5); rd(37, v);
    chk(v == -5, "R13 readback", v, -5);
    @(negedge clk); addr = 8'd37;
    @(negedge clk); addr = 8'd38; v = int'($signed(rdata));
    chk(v == -5, "R13 one-edge latency", v, -5);

    // R2/R3 directed row of four
    for (int a = 0; a < DEPTH; a++) orig[a] = 0;
    orig[0] = 10; orig[1] = 20; orig[2] = 30; orig[3] = 40;
    load_all(); run(0, 4, 1, 1, 0);
    for (int i = 0; i < 4; i++) begin
      rd(i, v); chk(v == exp4[i], $sformatf("R2 R3 row4 idx %0d", i), v, exp4[i]);
    end
    run(1, 4, 1, 1, 0); compare_all("R7 row4 restore");

    // R4 odd length with negative rounding
    for (int a = 0; a < DEPTH; a++) orig[a] = 0;
    orig[0] = 4; orig[1] = 8; orig[2] = 6; orig[3] = 2; orig[4] = 9;
    load_all(); run(0, 5, 1, 1, 0);
    for (int i = 0; i < 5; i++) begin
      rd(i, v); chk(v == exp5[i], $sformatf("R4 row5 idx %0d", i), v, exp5[i]);
    end
    run(1, 5, 1, 1, 0); compare_all("R7 row5 restore");

    // R10 zero levels
    for (int a = 0; a < DEPTH; a++) orig[a] = int'($urandom_range(255)) - 128;
    load_all();
    @(negedge clk); wid = 5'd16; hgt = 5'd16; lvls = 2'd0; inv = 0; start = 1;
    @(negedge clk); start = 0;
    chk(done == 1, "R10 done next cycle", int'(done), 1);
    compare_all("R10 memory unchanged");

    // R12 single pixel
    run(0, 1, 1, 2, 0);
    compare_all("R12 1x1 unchanged");

    // R9/R11 disturbed run, then random sizes R5 R6 R7
    for (int t = 0; t < 9; t++) begin
      int w = (t == 0) ? 16 : int'($urandom_range(16, 1));
      int h = (t == 0) ? 16 : int'($urandom_range(16, 1));
      int l = int'($urandom_range(3, 1));
      if (t == 1) begin w = 1; h = 7; end
      for (int a = 0; a < DEPTH; a++) orig[a] = int'($urandom_range(255)) - 128;
      load_all();
      run(0, w, h, l, t == 0);
      compare_all(t == 0 ? "R9 R11 disturbed forward" : "R5 R6 forward");
      run(1, w, h, l, 0);
      compare_all("R7 inverse restore");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule